// File: doc/BRIEF.md
# Bytecode Dispatch Fetch Unit

This block adds an interpreted-bytecode execution mode to a small processor core. It holds two architectural registers: a bytecode pointer, and the base of a handler table. While the mode is active it repeats one loop. It reads the byte at the pointer through a byte-wide memory port and advances the pointer. It then hands the core the fetch address of the native handler instruction for that byte, and waits for the core to retire that instruction.

If the retired handler was any kind of branch, the mode ends and the core's normal fetch takes over at the branch target. Otherwise the next byte is read and dispatched without software involvement. The handler table holds one 32-bit instruction per possible byte value, so it spans 1024 bytes and must sit on a 1024-byte boundary.

Software enters the mode with a one-cycle pulse that also supplies the starting pointer. Outside the mode, software can read and write both registers through a small select/write port.

Top module: `bc_dispatch_unit`

## Requirements
- R1: After reset the unit is out of bytecode mode (`mode_o` low), the pointer and table base both read 0, the misalignment flag is clear, and neither `bm_req_o` nor `fetch_valid_o` is raised.
- R2: An `enter_i` pulse while out of the mode loads the pointer from `enter_ip_i` and sets `mode_o` on the next cycle. In that same next cycle a byte read is raised at that pointer.
- R3: While a byte read is pending (`bm_req_o` high and `bm_valid_i` low), `bm_req_o` stays high, `bm_addr_o` holds its value and `fetch_valid_o` stays low.
- R4: The handler fetch address is the table base with bits 9:2 replaced by the fetched byte and bits 1:0 zero.
- R5: Each accepted byte (`bm_valid_i` high while `bm_req_o` is high) advances the pointer by exactly one, so successive reads use consecutive addresses.
- R6: `fetch_valid_o` is high for exactly one cycle, in the cycle right after a byte is accepted.
- R7: A retire with `retire_branch_i` low, while the unit waits for its handler, starts the next byte read in the following cycle.
- R8: A retire with `retire_branch_i` high ends the mode in the following cycle. No further byte reads follow, and the pointer is left one past the last dispatched byte.
- R9: A table-base write whose bits 9:0 are not all zero leaves the base unchanged and sets `misalign_o`. The flag stays set until reset, even across later aligned writes.
- R10: Software writes (`sw_sel_i` 0 selects the pointer, 1 selects the table base) take effect only while out of the mode; writes made during the mode are dropped. `sw_rdata_o` always shows the selected register.
- R11: An `enter_i` pulse during the mode has no effect on the pointer or on the dispatch sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_i | input | 1 | Pulse that starts bytecode mode |
| enter_ip_i | input | 32 | Starting bytecode pointer for `enter_i` |
| sw_we_i | input | 1 | Software register write strobe |
| sw_sel_i | input | 1 | Register select: 0 pointer, 1 table base |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Selected register value |
| misalign_o | output | 1 | Sticky misaligned-base error |
| mode_o | output | 1 | Bytecode mode active |
| bm_req_o | output | 1 | Byte read request |
| bm_addr_o | output | 32 | Byte read address |
| bm_valid_i | input | 1 | Byte read data valid |
| bm_data_i | input | 8 | Byte read data |
| fetch_valid_o | output | 1 | Handler fetch address valid (one cycle) |
| fetch_addr_o | output | 32 | Handler instruction fetch address |
| retire_i | input | 1 | Core retired the handler instruction |
| retire_branch_i | input | 1 | The retired handler was a branch |

## Verification
The following are checked on every cycle by the assertions:
- the pending-read hold;
- the one-cycle fetch pulse after each accepted byte;
- the pointer step;
- the shape of the handler address against the base;
- the stickiness of the error flag;
- the frozen base during the mode;
- the exits on branch and non-branch retires.

Only the directed scenarios can show the rest: the actual byte-to-address mapping over real table contents, including bytes 0x00 and 0xFF; dropped software writes and re-entry pulses seen afterwards through the register readback; the final pointer after a chain of handlers; and correct behaviour under varying memory latency.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDREQ = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } bcd_state_e;

    localparam logic SEL_PTR  = 1'b0;
    localparam logic SEL_BASE = 1'b1;

endpackage

// File: rtl/bcd_regs.sv
module bcd_regs #(
    parameter int ADDR_W = 32,
    parameter int TBL_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_i,
    input  logic                    load_ip_i,
    input  logic [ADDR_W-1:0]       enter_ip_i,
    input  logic                    step_i,
    input  logic                    sw_we_i,
    input  logic                    sw_sel_i,
    input  logic [ADDR_W-1:0]       sw_wdata_i,
    output logic [ADDR_W-1:0]       ip_o,
    output logic [ADDR_W-TBL_W-1:0] base_hi_o,
    output logic                    misalign_o,
    output logic [ADDR_W-1:0]       sw_rdata_o
);
    import bcd_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] ip;
        logic [ADDR_W-1:0] base;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_ip_i) begin
            r_d.ip = enter_ip_i;
        end else if (step_i) begin
            r_d.ip = r_q.ip + ADDR_W'(1);
        end else if (sw_we_i && !mode_i) begin
            if (sw_sel_i == SEL_PTR) begin
                r_d.ip = sw_wdata_i;
            end else if (|sw_wdata_i[TBL_W-1:0]) begin
                r_d.err = 1'b1;
            end else begin
                r_d.base = sw_wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ip_o       = r_q.ip;
    assign base_hi_o  = r_q.base[ADDR_W-1:TBL_W];
    assign misalign_o = r_q.err;
    assign sw_rdata_o = (sw_sel_i == SEL_BASE) ? r_q.base : r_q.ip;

    // R5: pointer advances by one per accepted byte
    a_r5_ip_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> r_q.ip == $past(r_q.ip) + ADDR_W'(1));

    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> r_q.err);

    // R9: stored base is always table aligned
    a_r9_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.base[TBL_W-1:0] == '0);

    // R10: base frozen while the mode is active
    a_r10_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |=> $stable(r_q.base));

endmodule

// File: rtl/bcd_ctrl.sv
module bcd_ctrl #(
    parameter int OP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter_i,
    input  logic            bm_valid_i,
    input  logic [OP_W-1:0] bm_data_i,
    input  logic            retire_i,
    input  logic            retire_branch_i,
    output logic            mode_o,
    output logic            load_ip_o,
    output logic            step_o,
    output logic            bm_req_o,
    output logic            fetch_valid_o,
    output logic [OP_W-1:0] opcode_o
);
    import bcd_pkg::*;

    typedef struct packed {
        bcd_state_e      state;
        logic [OP_W-1:0] opcode;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        load_ip_o = 1'b0;
        step_o    = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (enter_i) begin
                    c_d.state = ST_RDREQ;
                    load_ip_o = 1'b1;
                end
            end
            ST_RDREQ: begin
                if (bm_valid_i) begin
                    c_d.opcode = bm_data_i;
                    c_d.state  = ST_ISSUE;
                    step_o     = 1'b1;
                end
            end
            ST_ISSUE: begin
                c_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (retire_i) begin
                    c_d.state = retire_branch_i ? ST_IDLE : ST_RDREQ;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, opcode: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign mode_o        = (c_q.state != ST_IDLE);
    assign bm_req_o      = (c_q.state == ST_RDREQ);
    assign fetch_valid_o = (c_q.state == ST_ISSUE);
    assign opcode_o      = c_q.opcode;

    // R8: a branch retire ends the mode
    a_r8_branch_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_WAIT && retire_i && retire_branch_i) |=> !mode_o);

    // R7: a non-branch retire starts the next read
    a_r7_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_WAIT && retire_i && !retire_branch_i) |=> bm_req_o);

    // R2: entering raises a read on the next cycle
    a_r2_enter_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o && enter_i) |=> (mode_o && bm_req_o));

endmodule

// File: rtl/bc_dispatch_unit.sv
module bc_dispatch_unit #(
    parameter int ADDR_W     = 32,
    parameter int OP_W       = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  logic [ADDR_W-1:0] enter_ip_i,
    input  logic              sw_we_i,
    input  logic              sw_sel_i,
    input  logic [ADDR_W-1:0] sw_wdata_i,
    output logic [ADDR_W-1:0] sw_rdata_o,
    output logic              misalign_o,
    output logic              mode_o,
    output logic              bm_req_o,
    output logic [ADDR_W-1:0] bm_addr_o,
    input  logic              bm_valid_i,
    input  logic [OP_W-1:0]   bm_data_i,
    output logic              fetch_valid_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic              retire_i,
    input  logic              retire_branch_i
);
    localparam int SLOT_W = $clog2(INSN_BYTES);
    localparam int TBL_W  = OP_W + SLOT_W;

    logic                    load_ip, step;
    logic [OP_W-1:0]         opcode;
    logic [ADDR_W-1:0]       ip;
    logic [ADDR_W-TBL_W-1:0] base_hi;

    bcd_ctrl #(.OP_W(OP_W)) i_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .enter_i        (enter_i),
        .bm_valid_i     (bm_valid_i),
        .bm_data_i      (bm_data_i),
        .retire_i       (retire_i),
        .retire_branch_i(retire_branch_i),
        .mode_o         (mode_o),
        .load_ip_o      (load_ip),
        .step_o         (step),
        .bm_req_o       (bm_req_o),
        .fetch_valid_o  (fetch_valid_o),
        .opcode_o       (opcode)
    );

    bcd_regs #(.ADDR_W(ADDR_W), .TBL_W(TBL_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_o),
        .load_ip_i  (load_ip),
        .enter_ip_i (enter_ip_i),
        .step_i     (step),
        .sw_we_i    (sw_we_i),
        .sw_sel_i   (sw_sel_i),
        .sw_wdata_i (sw_wdata_i),
        .ip_o       (ip),
        .base_hi_o  (base_hi),
        .misalign_o (misalign_o),
        .sw_rdata_o (sw_rdata_o)
    );

    assign bm_addr_o    = ip;
    assign fetch_addr_o = {base_hi, opcode, {SLOT_W{1'b0}}};

    // R3: pending read holds its request and address
    a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req_o && !bm_valid_i) |=> (bm_req_o && $stable(bm_addr_o)));

    // R3: no handler fetch while a read is pending
    a_r3_no_fetch_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req_o |-> !fetch_valid_o);

    // R6: one fetch pulse right after each accepted byte
    a_r6_fetch_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req_o && bm_valid_i) |=> fetch_valid_o);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o |=> !fetch_valid_o);

    // R4: handler address keeps the base above the table and a zero slot offset
    a_r4_addr_shape: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o |-> (fetch_addr_o[ADDR_W-1:TBL_W] == base_hi &&
                           fetch_addr_o[SLOT_W-1:0] == '0));

endmodule

// File: tb/test_bc_dispatch_unit.sv
module test_bc_dispatch_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enter_i;
    logic [31:0] enter_ip_i;
    logic        sw_we_i;
    logic        sw_sel_i;
    logic [31:0] sw_wdata_i;
    logic [31:0] sw_rdata_o;
    logic        misalign_o, mode_o, bm_req_o, fetch_valid_o;
    logic [31:0] bm_addr_o, fetch_addr_o;
    logic        bm_valid_i;
    logic [7:0]  bm_data_i;
    logic        retire_i, retire_branch_i;

    int n_checks = 0;
    int n_fail   = 0;
    int lat      = 0;
    int wait_cnt = 0;
    int cycles   = 0;
    bit done     = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] cur_base  = '0;
    logic [7:0]  bmem [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    bc_dispatch_unit i_bc_dispatch_unit (
        .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .enter_ip_i(enter_ip_i),
        .sw_we_i(sw_we_i), .sw_sel_i(sw_sel_i), .sw_wdata_i(sw_wdata_i),
        .sw_rdata_o(sw_rdata_o), .misalign_o(misalign_o), .mode_o(mode_o),
        .bm_req_o(bm_req_o), .bm_addr_o(bm_addr_o), .bm_valid_i(bm_valid_i),
        .bm_data_i(bm_data_i), .fetch_valid_o(fetch_valid_o),
        .fetch_addr_o(fetch_addr_o), .retire_i(retire_i),
        .retire_branch_i(retire_branch_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // byte memory model: answers a request after lat waiting cycles
    initial begin
        bm_valid_i = 1'b0;
        bm_data_i  = '0;
        forever begin
            @(negedge clk);
            if (bm_valid_i) begin
                bm_valid_i = 1'b0;
                wait_cnt   = 0;
            end else if (bm_req_o) begin
                if (wait_cnt >= lat) begin
                    bm_valid_i = 1'b1;
                    bm_data_i  = bmem[bm_addr_o[7:0]];
                    last_addr  = bm_addr_o;
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                chk(1'b0, "watchdog", cycles, 20000);
                finish_run();
            end
        end
    end

    task automatic sw_write(input logic sel, input logic [31:0] val);
        @(negedge clk);
        sw_we_i = 1'b1; sw_sel_i = sel; sw_wdata_i = val;
        @(negedge clk);
        sw_we_i = 1'b0;
    endtask

    task automatic sw_read(input logic sel, output logic [31:0] val);
        sw_sel_i = sel;
        #1;
        val = sw_rdata_o;
    endtask

    // runs n handlers starting at ptr; last one branches; poke tries writes during the mode
    task automatic run_seq(input logic [31:0] ptr, input int n, input int latency,
                           input bit poke);
        logic [31:0] exp_addr, rd;
        lat = latency;
        @(negedge clk);
        enter_i = 1'b1; enter_ip_i = ptr;
        @(negedge clk);
        enter_i = 1'b0;
        chk(mode_o == 1'b1, "R2 mode set", {31'd0, mode_o}, 1);
        chk(bm_req_o == 1'b1 && bm_addr_o == ptr, "R2 first read", bm_addr_o, ptr);
        for (int k = 0; k < n; k++) begin
            int guard = 0;
            while (!fetch_valid_o && guard < 60) begin
                @(negedge clk);
                guard++;
            end
            exp_addr = {cur_base[31:10], bmem[8'(ptr + 32'(k))], 2'b00};
            chk(fetch_valid_o, "R6 fetch pulse", {31'd0, fetch_valid_o}, 1);
            chk(fetch_addr_o == exp_addr, "R4 handler addr", fetch_addr_o, exp_addr);
            chk(last_addr == ptr + 32'(k), "R5 read addr", last_addr, ptr + 32'(k));
            if (poke && k == 0) begin
                enter_i = 1'b1; enter_ip_i = 32'h0000_0F00;
                sw_we_i = 1'b1; sw_sel_i = 1'b0; sw_wdata_i = 32'h1234_5678;
            end
            @(negedge clk);
            enter_i = 1'b0;
            if (poke && k == 0) begin
                sw_sel_i = 1'b1; sw_wdata_i = 32'hAAAA_0000;
            end
            chk(!fetch_valid_o, "R6 pulse width", {31'd0, fetch_valid_o}, 0);
            retire_i = 1'b1; retire_branch_i = (k == n - 1);
            @(negedge clk);
            retire_i = 1'b0; retire_branch_i = 1'b0; sw_we_i = 1'b0;
            if (k < n - 1)
                chk(bm_req_o, "R7 next read", {31'd0, bm_req_o}, 1);
        end
        chk(!mode_o, "R8 mode exit", {31'd0, mode_o}, 0);
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chk(!bm_req_o, "R8 no read after exit", {31'd0, bm_req_o}, 0);
        end
        sw_read(1'b0, rd);
        chk(rd == ptr + 32'(n), "R8 final pointer", rd, ptr + 32'(n));
    endtask

    task automatic t_reset();
        logic [31:0] rd;
        chk(!mode_o && !bm_req_o && !fetch_valid_o, "R1 idle outputs",
            {29'd0, mode_o, bm_req_o, fetch_valid_o}, 0);
        chk(!misalign_o, "R1 flag clear", {31'd0, misalign_o}, 0);
        sw_read(1'b0, rd); chk(rd == 0, "R1 pointer zero", rd, 0);
        sw_read(1'b1, rd); chk(rd == 0, "R1 base zero", rd, 0);
    endtask

    task automatic t_base_writes();
        logic [31:0] rd;
        sw_write(1'b1, 32'h0000_4C00); cur_base = 32'h0000_4C00;
        sw_read(1'b1, rd); chk(rd == 32'h0000_4C00, "R10 base write", rd, 32'h4C00);
        sw_write(1'b0, 32'h0000_0040);
        sw_read(1'b0, rd); chk(rd == 32'h40, "R10 pointer write", rd, 32'h40);
        sw_write(1'b1, 32'h0000_8004);
        sw_read(1'b1, rd); chk(rd == 32'h0000_4C00, "R9 misaligned ignored", rd, 32'h4C00);
        chk(misalign_o, "R9 flag set", {31'd0, misalign_o}, 1);
        sw_write(1'b1, 32'h0001_0000); cur_base = 32'h0001_0000;
        sw_read(1'b1, rd); chk(rd == 32'h0001_0000, "R10 aligned after error", rd, 32'h10000);
        chk(misalign_o, "R9 flag sticky", {31'd0, misalign_o}, 1);
    endtask

    task automatic t_single_branch();
        bmem[8'h10] = 8'hFF;
        run_seq(32'h0000_0010, 1, 0, 1'b0);
    endtask

    task automatic t_chain_slow();
        bmem[8'h20] = 8'h00; bmem[8'h21] = 8'h80; bmem[8'h22] = 8'h3C;
        bmem[8'h23] = 8'h01; bmem[8'h24] = 8'hFE;
        run_seq(32'h0000_0020, 5, 3, 1'b0);
    endtask

    task automatic t_locked();
        logic [31:0] rd;
        bmem[8'h50] = 8'h11; bmem[8'h51] = 8'h22; bmem[8'h52] = 8'h33;
        run_seq(32'h0000_0050, 3, 1, 1'b1);
        sw_read(1'b0, rd); chk(rd == 32'h53, "R11 enter ignored in mode", rd, 32'h53);
        sw_read(1'b1, rd); chk(rd == cur_base, "R10 base write dropped in mode", rd, cur_base);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) bmem[a] = 8'(a * 7);
        rst_n = 1'b0; enter_i = 1'b0; enter_ip_i = '0; sw_we_i = 1'b0;
        sw_sel_i = 1'b0; sw_wdata_i = '0; retire_i = 1'b0; retire_branch_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base_writes();
        t_single_branch();
        t_chain_slow();
        t_locked();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule